// File: doc/BRIEF.md
# Pin Controller with Per-Line Interrupt Sense

This block controls 32 general-purpose pins through six word-wide registers on a small request/response bus. Each pin has a direction bit, an output-data bit and an input-data bit that shows the pin's synchronized level. Software can change the output-data bits in three ways: it can write the whole word, or it can write to a set alias or a clear alias, which change only the bits written as 1.

The low 16 pins each drive one interrupt line toward a parent interrupt controller. The parent accepts active-high lines only and does its own masking, acknowledgement and edge/level capture. A per-line mode bit and the line's output-data bit together shape what the parent sees:
- With the mode bit clear, the line follows the pin when the output-data bit is 0, and follows the inverted pin when that bit is 1. This gives the parent both polarities.
- With the mode bit set, the line gives a one-cycle pulse whenever the synchronized pin changes, in either direction, and the output-data bit has no effect on that line.

The bus uses a valid/ready request channel and a valid/ready response channel. A request is accepted on a clock edge where `bus_valid` and `bus_ready` are both high. Every accepted request, read or write, returns exactly one response beat. The response is held until `rsp_ready` is high. While a response is waiting, `bus_ready` stays low, so there is at most one transaction in flight.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, the direction, output-data and mode registers read zero, `pin_oe` is 0, `rsp_valid` is 0 and `bus_ready` is 1.
- R2: Direction register is at byte offset 0x00. `pin_oe` equals the direction register, so a bit of 1 drives the pin and a bit of 0 leaves it undriven. `pin_out` always equals the output-data register.
- R3: The input-data register is at offset 0x08 and returns `pin_in` after two synchronizer flops. A pin change driven before edge k is first returned by a read accepted at edge k+2.
- R4: The set alias is at offset 0x18. A write there forces high every output-data bit written as 1 and leaves the other bits unchanged. Reads of this offset return zero.
- R5: The clear alias is at offset 0x20. A write there forces low every output-data bit written as 1 and leaves the other bits unchanged. Reads of this offset return zero.
- R6: The output-data register is at offset 0x10. For a line in 0..15 with mode bit 0 and output-data bit 0, `irq_out[i]` equals the synchronized pin.
- R7: For a line in 0..15 with mode bit 0 and output-data bit 1, `irq_out[i]` equals the inverse of the synchronized pin.
- R8: The mode register is at offset 0x30, and bit i belongs to line i. With the mode bit at 1, `irq_out[i]` is high for exactly the one cycle after each change of the synchronized pin, whichever value the output-data bit has.
- R9: Only pins 0..15 have interrupt lines. Mode bits 31..16 are not stored and read back as zero, and pins 16..31 never affect `irq_out`.
- R10: Reads of any offset not named above return zero. Writes to such offsets change no register.
- R11: While `rsp_valid` is high and `rsp_ready` is low, `bus_ready` is low, `rsp_data` holds its value and no request is accepted. Every write returns a response beat with data zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Request valid |
| bus_ready | output | 1 | Request can be accepted |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response beat valid |
| rsp_ready | input | 1 | Response beat taken |
| rsp_data | output | 32 | Read data (zero for writes) |
| pin_in | input | 32 | Asynchronous pin levels |
| pin_out | output | 32 | Pin output levels |
| pin_oe | output | 32 | Pin output enables |
| irq_out | output | 16 | Active-high interrupt lines to the parent |

## Verification
The assertions check the bus handshake on every cycle: a response is held under back-pressure, and no request is taken while a response waits. They also check that the output enables change only after an accepted write, and that the set and clear aliases act on exactly the bits written. Some behaviour can only be shown by the bench's scenarios. These are the two-cycle input latency, the polarity inversion from the output-data bit, the single-cycle pulse in both-edge mode with the output-data bit ignored, and the absence of effect from the upper pins and from unmapped offsets. A model also follows random register traffic and checks it through read-back and the pin outputs.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFS_DIR  = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_IN   = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_OUT  = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_SET  = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_CLR  = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_MODE = 8'h30;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_DIR,
    SEL_IN,
    SEL_OUT,
    SEL_SET,
    SEL_CLR,
    SEL_MODE
  } reg_sel_e;

  function automatic reg_sel_e decode(input logic [ADDR_W-1:0] a);
    case (a)
      OFS_DIR:  return SEL_DIR;
      OFS_IN:   return SEL_IN;
      OFS_OUT:  return SEL_OUT;
      OFS_SET:  return SEL_SET;
      OFS_CLR:  return SEL_CLR;
      OFS_MODE: return SEL_MODE;
      default:  return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[0] <= '0;
          else        stage_q[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_irq_pkg::*;
#(
  parameter int NPIN = 32,
  parameter int NIRQ = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  output logic              bus_ready,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NPIN-1:0]   bus_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [NPIN-1:0]   rsp_data,
  input  logic [NPIN-1:0]   pin_sync,
  output logic [NPIN-1:0]   dir_q,
  output logic [NPIN-1:0]   odata_q,
  output logic [NIRQ-1:0]   mode_q
);
  logic            accept;
  reg_sel_e        sel;
  logic [NPIN-1:0] mode_ext;
  logic [NPIN-1:0] rd_mux;
  logic            rsp_valid_q;
  logic [NPIN-1:0] rsp_data_q;

  assign bus_ready = ~rsp_valid_q;
  assign accept    = bus_valid & bus_ready;
  assign sel       = decode(bus_addr);

  always_comb begin
    mode_ext             = '0;
    mode_ext[NIRQ-1:0]   = mode_q;
  end

  always_comb begin
    case (sel)
      SEL_DIR:  rd_mux = dir_q;
      SEL_IN:   rd_mux = pin_sync;
      SEL_OUT:  rd_mux = odata_q;
      SEL_MODE: rd_mux = mode_ext;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= '0;
      odata_q <= '0;
      mode_q  <= '0;
    end else if (accept && bus_write) begin
      case (sel)
        SEL_DIR:  dir_q   <= bus_wdata;
        SEL_OUT:  odata_q <= bus_wdata;
        SEL_SET:  odata_q <= odata_q | bus_wdata;
        SEL_CLR:  odata_q <= odata_q & ~bus_wdata;
        SEL_MODE: mode_q  <= bus_wdata[NIRQ-1:0];
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else if (accept) begin
      rsp_valid_q <= 1'b1;
      rsp_data_q  <= bus_write ? '0 : rd_mux;
    end else if (rsp_ready) begin
      rsp_valid_q <= 1'b0;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_data  = rsp_data_q;
endmodule

// File: rtl/gpio_irq_gen.sv
module gpio_irq_gen #(
  parameter int NIRQ = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NIRQ-1:0] pin_sync,
  input  logic [NIRQ-1:0] invert,
  input  logic [NIRQ-1:0] both_edge,
  output logic [NIRQ-1:0] irq
);
  logic [NIRQ-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= pin_sync;
  end

  generate
    for (genvar i = 0; i < NIRQ; i++) begin : g_line
      logic level_s;
      logic change_s;
      assign level_s  = pin_sync[i] ^ invert[i];
      assign change_s = pin_sync[i] ^ prev_q[i];
      assign irq[i]   = both_edge[i] ? change_s : level_s;
    end
  endgenerate
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int NPIN        = 32,
  parameter int NIRQ        = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  output logic              bus_ready,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NPIN-1:0]   bus_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [NPIN-1:0]   rsp_data,
  input  logic [NPIN-1:0]   pin_in,
  output logic [NPIN-1:0]   pin_out,
  output logic [NPIN-1:0]   pin_oe,
  output logic [NIRQ-1:0]   irq_out
);
  logic [NPIN-1:0] pin_sync;
  logic [NPIN-1:0] dir_q;
  logic [NPIN-1:0] odata_q;
  logic [NIRQ-1:0] mode_q;

  gpio_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst_n (rst_n),
    .d (pin_in),
    .q (pin_sync)
  );

  gpio_regfile #(.NPIN(NPIN), .NIRQ(NIRQ)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_ready (bus_ready),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_data  (rsp_data),
    .pin_sync  (pin_sync),
    .dir_q     (dir_q),
    .odata_q   (odata_q),
    .mode_q    (mode_q)
  );

  gpio_irq_gen #(.NIRQ(NIRQ)) u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_sync  (pin_sync[NIRQ-1:0]),
    .invert    (odata_q[NIRQ-1:0]),
    .both_edge (mode_q),
    .irq       (irq_out)
  );

  assign pin_oe  = dir_q;
  assign pin_out = odata_q;
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk
  import gpio_irq_pkg::*;
#(
  parameter int NPIN = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_valid,
  input logic              bus_ready,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [NPIN-1:0]   bus_wdata,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [NPIN-1:0]   rsp_data,
  input logic [NPIN-1:0]   pin_out,
  input logic [NPIN-1:0]   pin_oe
);
  logic acc_wr;
  assign acc_wr = bus_valid && bus_ready && bus_write;

  // R11
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  // R11
  no_accept_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !bus_ready);

  // R2
  oe_write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_wr |=> $stable(pin_oe));

  // R4
  set_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && bus_addr == OFS_SET) |=>
      ((pin_out & $past(bus_wdata)) == $past(bus_wdata)));

  // R5
  clr_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && bus_addr == OFS_CLR) |=>
      ((pin_out & $past(bus_wdata)) == '0));
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.NPIN(NPIN)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_valid (bus_valid),
  .bus_ready (bus_ready),
  .bus_write (bus_write),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_data  (rsp_data),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe)
);

// File: tb/gpio_irq_ctrl_bench.sv
module gpio_irq_ctrl_bench;
  localparam int NPIN = 32;
  localparam int NIRQ = 16;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            bus_valid = 1'b0;
  logic            bus_ready;
  logic            bus_write = 1'b0;
  logic [7:0]      bus_addr = '0;
  logic [NPIN-1:0] bus_wdata = '0;
  logic            rsp_valid;
  logic            rsp_ready = 1'b0;
  logic [NPIN-1:0] rsp_data;
  logic [NPIN-1:0] pin_in = '0;
  logic [NPIN-1:0] pin_out;
  logic [NPIN-1:0] pin_oe;
  logic [NIRQ-1:0] irq_out;

  int checks = 0;
  int errors = 0;

  logic [31:0] m_dir = '0, m_odata = '0, m_mode = '0;

  always #4 clk = ~clk;

  gpio_irq_ctrl u_gpio_irq_ctrl (
    .clk (clk), .rst_n (rst_n),
    .bus_valid (bus_valid), .bus_ready (bus_ready), .bus_write (bus_write),
    .bus_addr (bus_addr), .bus_wdata (bus_wdata),
    .rsp_valid (rsp_valid), .rsp_ready (rsp_ready), .rsp_data (rsp_data),
    .pin_in (pin_in), .pin_out (pin_out), .pin_oe (pin_oe), .irq_out (irq_out)
  );

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    case (a)
      8'h00:   return m_dir;
      8'h08:   return pin_in;
      8'h10:   return m_odata;
      8'h30:   return m_mode;
      default: return 32'h0;
    endcase
  endfunction

  function automatic void model_write(input logic [7:0] a, input logic [31:0] d);
    case (a)
      8'h00: m_dir = d;
      8'h10: m_odata = d;
      8'h18: m_odata = m_odata | d;
      8'h20: m_odata = m_odata & ~d;
      8'h30: m_mode = {16'h0, d[15:0]};
      default: ;
    endcase
  endfunction

  // steady-state line value: edge lines idle low once the pin is stable
  function automatic logic [15:0] exp_irq();
    logic [15:0] r;
    for (int i = 0; i < 16; i++)
      r[i] = m_mode[i] ? 1'b0 : (pin_in[i] ^ m_odata[i]);
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic bus_op(input bit wr, input logic [7:0] a,
                        input logic [31:0] d, output logic [31:0] r);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = wr; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0;
    r = rsp_valid ? rsp_data : 32'hDEAD_BEEF;
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    if (wr) model_write(a, d);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    logic [31:0] r;
    bus_op(1'b1, a, d, r);
    check("R11", r, 32'h0, "write response data");
  endtask

  task automatic rd_check(input string req, input logic [7:0] a);
    logic [31:0] r;
    logic [31:0] e;
    e = exp_read(a);
    bus_op(1'b0, a, 32'h0, r);
    check(req, r, e, $sformatf("read 0x%02h", a));
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [31:0] r, held;
    logic [7:0] offs [6];
    void'($urandom(32'h5EED_1234));
    offs[0] = 8'h00; offs[1] = 8'h08; offs[2] = 8'h10;
    offs[3] = 8'h18; offs[4] = 8'h20; offs[5] = 8'h30;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", pin_oe, 32'h0, "pin_oe after reset");
    check("R1", {31'h0, rsp_valid}, 32'h0, "rsp_valid after reset");
    check("R1", {31'h0, bus_ready}, 32'h1, "bus_ready after reset");
    rd_check("R1", 8'h00);
    rd_check("R1", 8'h10);
    rd_check("R1", 8'h30);

    // R2 direction and output data
    wr(8'h00, 32'hA5A5_0FF0);
    wr(8'h10, 32'h1234_5678);
    check("R2", pin_oe, 32'hA5A5_0FF0, "pin_oe");
    check("R2", pin_out, 32'h1234_5678, "pin_out");

    // R4 set alias, R5 clear alias
    wr(8'h18, 32'h8000_0001);
    check("R4", pin_out, 32'h9234_5679, "pin_out after set");
    rd_check("R4", 8'h18);
    wr(8'h20, 32'h0000_0078);
    check("R5", pin_out, 32'h9234_5601, "pin_out after clear");
    rd_check("R5", 8'h20);

    // R3 two-flop latency: first read sees the old value, the next sees the new
    @(negedge clk);
    pin_in = 32'hC3C3_5A5A;
    bus_op(1'b0, 8'h08, 32'h0, r);
    check("R3", r, 32'h0, "input read one edge after change");
    rd_check("R3", 8'h08);

    // R6 / R7 polarity, mode off
    wr(8'h30, 32'h0);
    wr(8'h10, 32'h0000_F0F0);
    repeat (3) @(negedge clk);
    check("R6", {16'h0, irq_out & ~m_odata[15:0]}, {16'h0, exp_irq() & ~m_odata[15:0]}, "noninverted lines");
    check("R7", {16'h0, irq_out & m_odata[15:0]}, {16'h0, exp_irq() & m_odata[15:0]}, "inverted lines");

    // R8 both-edge pulse on line 3 with output-data bit 3 set (ignored)
    wr(8'h30, 32'h0000_0008);
    wr(8'h18, 32'h0000_0008);
    pin_in[3] = 1'b0;
    repeat (4) @(negedge clk);
    check("R8", {31'h0, irq_out[3]}, 32'h0, "edge line idle");
    for (int k = 0; k < 2; k++) begin
      pin_in[3] = ~pin_in[3];
      @(negedge clk);
      check("R8", {31'h0, irq_out[3]}, 32'h0, "before sync");
      @(negedge clk);
      check("R8", {31'h0, irq_out[3]}, 32'h1, "pulse cycle");
      @(negedge clk);
      check("R8", {31'h0, irq_out[3]}, 32'h0, "pulse ended");
    end

    // R9 upper pins have no lines, upper mode bits not stored
    wr(8'h30, 32'hFFFF_0000);
    rd_check("R9", 8'h30);
    held = {16'h0, irq_out};
    pin_in[31:16] = ~pin_in[31:16];
    repeat (4) @(negedge clk);
    check("R9", {16'h0, irq_out}, held, "irq after upper pin change");

    // R10 unmapped offsets
    wr(8'h04, 32'hFFFF_FFFF);
    wr(8'h28, 32'hFFFF_FFFF);
    wr(8'h31, 32'hFFFF_FFFF);
    rd_check("R10", 8'h04);
    rd_check("R10", 8'h3C);
    rd_check("R10", 8'h00);
    rd_check("R10", 8'h10);
    rd_check("R10", 8'h30);

    // R11 back-pressure: response held, competing write refused
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = 8'h10;
    @(negedge clk);
    held = rsp_data;
    bus_write = 1'b1; bus_addr = 8'h00; bus_wdata = 32'h0;
    repeat (3) begin
      @(negedge clk);
      check("R11", {30'h0, rsp_valid, bus_ready}, 32'h2, "valid high, ready low");
      check("R11", rsp_data, held, "held response data");
    end
    check("R11", held, m_odata, "held response value");
    bus_valid = 1'b0; rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    check("R11", pin_oe, m_dir, "refused write had no effect");

    // random traffic against the model
    for (int n = 0; n < 80; n++) begin
      logic [7:0] a;
      logic [31:0] d;
      a = ($urandom % 8 == 0) ? 8'($urandom) : offs[$urandom % 6];
      d = $urandom;
      if ($urandom % 2 == 1) wr(a, d);
      else pin_in = $urandom;
      repeat (3) @(negedge clk);
      check("R2", pin_oe, m_dir, "random pin_oe");
      check("R2", pin_out, m_odata, "random pin_out");
      check("R6", {16'h0, irq_out}, {16'h0, exp_irq()}, "random irq");
      rd_check("R10", offs[$urandom % 6]);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule